// File: doc/BRIEF.md
# Programmable Bytewise CRC Engine

This block computes a cyclic redundancy check over a packet presented one byte per clock, and either appends the result (transmit) or compares it against the check field that follows the data (receive). All of its arithmetic is set at run time: the check width in whole octets (0 to 4), the generator polynomial, the start value, the final XOR mask, bit reversal of each incoming byte, bit reversal of the whole finished result, the order in which the result bytes go out or are compared, and a count of leading packet bytes left out of the sum.

A packet starts with a byte flagged as start-of-packet and its data portion ends with a byte flagged as end-of-data. The direction is sampled with the first byte. In transmit, the engine drives the check bytes on its output port in the cycles right after the last data byte. In receive, the next N accepted bytes are taken as the received check field; once the last of them arrives the engine updates a sticky pass flag and, subject to a policy input, pulses a receive-done indication. Configuration inputs must be held stable while a packet is in flight.

Top module: `crc_engine`

## Requirements
- R1: While reset is high and in the cycle after it, out_valid, out_last and rx_done are 0 and crc_ok is 0.
- R2: In transmit, N check bytes (N = effective size) appear on out_data in N consecutive cycles, the first one the cycle after the end-of-data byte is accepted; out_last is 1 only with the last of them; input bytes are ignored while they are emitted.
- R3: With an effective size of 0 nothing is emitted in transmit, and in receive rx_done and crc_ok both read 1 in the cycle after the end-of-data byte.
- R4: The first cfg_skip bytes of a packet, counting the start-of-packet byte as byte 0, are not accumulated.
- R5: With cfg_refl_in = 1, each data byte is bit-reversed before it enters the sum; with 0, bit 7 of each byte enters first.
- R6: With cfg_refl_out = 1, the whole W-bit result (W = 8*N) is bit-reversed before the final XOR; the reversal spans the full width, not single bytes.
- R7: cfg_msb_first = 0 sends and compares result bits 7:0 first; 1 sends and compares bits W-1:W-8 first.
- R8: For W below 32 only the low W bits of cfg_seed, cfg_poly and cfg_xor_out have any effect.
- R9: In receive, crc_ok becomes 1 at the end of the check field if and only if every received check byte equals the expected byte in the selected order.
- R10: A failing check raises rx_done (a one-cycle pulse) only when cfg_ignore_bad = 1; a passing check always raises it.
- R11: crc_ok holds its value between checks and is cleared to 0 when a new packet starts.
- R12: A cfg_size value above 4 behaves exactly as 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_size | input | 3 | Check size in octets |
| cfg_skip | input | 4 | Leading bytes excluded from the sum |
| cfg_refl_in | input | 1 | Reverse bits of each input byte |
| cfg_refl_out | input | 1 | Reverse bits of the whole result |
| cfg_msb_first | input | 1 | Result byte order (1 = most significant first) |
| cfg_seed | input | 32 | Start value, low W bits used |
| cfg_poly | input | 32 | Generator polynomial, low W bits used |
| cfg_xor_out | input | 32 | Final XOR mask, low W bits used |
| cfg_ignore_bad | input | 1 | Raise rx_done even on a failed check |
| tx_mode | input | 1 | 1 = generate, 0 = check; sampled at start of packet |
| in_valid | input | 1 | Input byte valid |
| in_sop | input | 1 | Byte is first of packet |
| in_eod | input | 1 | Byte is last data byte |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Check byte valid (transmit) |
| out_data | output | 8 | Check byte |
| out_last | output | 1 | Last check byte |
| rx_done | output | 1 | Receive-done pulse |
| crc_ok | output | 1 | Result of the latest check |

## Verification
A corrupted accumulator shows up at the ports within one cycle of the end-of-data byte, as a wrong first check byte in transmit or a failed comparison in receive, so known-answer packets with fixed expected bytes expose it directly. A wrong byte index or state shows as a missing, extra or misordered byte, or a misplaced out_last, within N+1 cycles; a wrong skip count or reflection changes every check byte of that packet. Errors in the pass flag persist until the next start-of-packet, so they are visible for the whole idle gap.

// File: rtl/crc_engine_pkg.sv
package crc_engine_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DATA  = 2'd1,
    ST_EMIT  = 2'd2,
    ST_CHECK = 2'd3
  } crc_state_t;

  function automatic logic [BYTE_W-1:0] flip_byte(input logic [BYTE_W-1:0] b);
    logic [BYTE_W-1:0] r;
    for (int i = 0; i < BYTE_W; i++) r[i] = b[BYTE_W-1-i];
    return r;
  endfunction
endpackage

// File: rtl/crc_byte_step.sv
module crc_byte_step #(
  parameter int CW = 32
) (
  input  logic [CW-1:0] crc_in,
  input  logic [CW-1:0] poly,
  input  logic [7:0]    data,
  output logic [CW-1:0] crc_out
);
  logic [8:0][CW-1:0] chain;

  assign chain[0] = crc_in;

  for (genvar b = 0; b < 8; b++) begin : g_bit
    logic fb;
    assign fb          = chain[b][CW-1] ^ data[7-b];
    assign chain[b+1]  = {chain[b][CW-2:0], 1'b0} ^ (fb ? poly : '0);
  end

  assign crc_out = chain[8];
endmodule

// File: rtl/crc_finalize.sv
module crc_finalize #(
  parameter int CW  = 32,
  parameter int SHW = 6
) (
  input  logic [CW-1:0]  acc,
  input  logic [SHW-1:0] shamt,
  input  logic           refl_out,
  input  logic [CW-1:0]  xor_out,
  output logic [CW-1:0]  result
);
  logic [CW-1:0] acc_rev;
  logic [CW-1:0] mask;

  for (genvar i = 0; i < CW; i++) begin : g_rev
    assign acc_rev[i] = acc[CW-1-i];
  end

  assign mask   = {CW{1'b1}} >> shamt;
  assign result = ((refl_out ? acc_rev : (acc >> shamt)) ^ xor_out) & mask;
endmodule

// File: rtl/crc_engine.sv
module crc_engine
  import crc_engine_pkg::*;
#(
  parameter int MAX_OCTETS = 4,
  parameter int SIZE_W     = 3,
  parameter int SKIP_W     = 4,
  localparam int CW        = 8 * MAX_OCTETS,
  localparam int IDXW      = $clog2(MAX_OCTETS + 1),
  localparam int SHW       = $clog2(CW + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SIZE_W-1:0] cfg_size,
  input  logic [SKIP_W-1:0] cfg_skip,
  input  logic              cfg_refl_in,
  input  logic              cfg_refl_out,
  input  logic              cfg_msb_first,
  input  logic [CW-1:0]     cfg_seed,
  input  logic [CW-1:0]     cfg_poly,
  input  logic [CW-1:0]     cfg_xor_out,
  input  logic              cfg_ignore_bad,
  input  logic              tx_mode,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic              in_eod,
  input  logic [7:0]        in_data,
  output logic              out_valid,
  output logic [7:0]        out_data,
  output logic              out_last,
  output logic              rx_done,
  output logic              crc_ok
);
  crc_state_t        st_q;
  logic [CW-1:0]     crc_q;
  logic [SKIP_W-1:0] skip_q;
  logic [IDXW-1:0]   idx_q;
  logic              bad_q;
  logic              tx_q;

  logic [IDXW-1:0]   eff_sz;
  logic [SHW-1:0]    shamt;
  logic [CW-1:0]     seed_al, poly_al;
  logic [7:0]        din;
  logic [CW-1:0]     step_base, step_out, result, res_sh;
  logic [IDXW-1:0]   pos;
  logic [7:0]        exp_byte;
  logic              accept, starting, skipping, eod_now, tx_eff, idx_last, mism;

  always_comb begin
    eff_sz   = (cfg_size > SIZE_W'(MAX_OCTETS)) ? IDXW'(MAX_OCTETS) : IDXW'(cfg_size);
    shamt    = SHW'(CW - 8 * int'(eff_sz));
    seed_al  = cfg_seed << shamt;
    poly_al  = cfg_poly << shamt;
    din      = cfg_refl_in ? flip_byte(in_data) : in_data;
    accept   = in_valid && (st_q != ST_EMIT);
    starting = accept && in_sop;
    skipping = starting ? (cfg_skip != '0) : (skip_q != '0);
    step_base = starting ? seed_al : crc_q;
    eod_now  = accept && in_eod && (starting || st_q == ST_DATA);
    tx_eff   = starting ? tx_mode : tx_q;
    idx_last = (idx_q == eff_sz - IDXW'(1));
    pos      = cfg_msb_first ? (eff_sz - IDXW'(1) - idx_q) : idx_q;
    res_sh   = result >> {pos, 3'b000};
    exp_byte = res_sh[7:0];
    mism     = (in_data != exp_byte);
  end

  crc_byte_step #(.CW(CW)) step_i (
    .crc_in (step_base),
    .poly   (poly_al),
    .data   (din),
    .crc_out(step_out)
  );

  crc_finalize #(.CW(CW), .SHW(SHW)) fin_i (
    .acc     (crc_q),
    .shamt   (shamt),
    .refl_out(cfg_refl_out),
    .xor_out (cfg_xor_out),
    .result  (result)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      crc_q     <= '0;
      skip_q    <= '0;
      idx_q     <= '0;
      bad_q     <= 1'b0;
      tx_q      <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
      rx_done   <= 1'b0;
      crc_ok    <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      rx_done   <= 1'b0;
      if (starting) begin
        tx_q   <= tx_mode;
        crc_ok <= 1'b0;
        idx_q  <= '0;
        bad_q  <= 1'b0;
        crc_q  <= skipping ? seed_al : step_out;
        skip_q <= skipping ? cfg_skip - SKIP_W'(1) : '0;
        st_q   <= ST_DATA;
      end else begin
        case (st_q)
          ST_DATA: begin
            if (in_valid) begin
              if (skipping) skip_q <= skip_q - SKIP_W'(1);
              else          crc_q  <= step_out;
            end
          end
          ST_EMIT: begin
            out_valid <= 1'b1;
            out_data  <= exp_byte;
            out_last  <= idx_last;
            idx_q     <= idx_q + IDXW'(1);
            if (idx_last) st_q <= ST_IDLE;
          end
          ST_CHECK: begin
            if (in_valid) begin
              idx_q <= idx_q + IDXW'(1);
              if (idx_last) begin
                crc_ok  <= !(bad_q || mism);
                rx_done <= !(bad_q || mism) || cfg_ignore_bad;
                st_q    <= ST_IDLE;
              end else begin
                bad_q <= bad_q || mism;
              end
            end
          end
          default: ;
        endcase
      end
      if (eod_now) begin
        if (eff_sz == '0) begin
          st_q <= ST_IDLE;
          if (!tx_eff) begin
            crc_ok  <= 1'b1;
            rx_done <= 1'b1;
          end
        end else begin
          st_q <= tx_eff ? ST_EMIT : ST_CHECK;
        end
      end
    end
  end
endmodule

// File: rtl/crc_engine_chk.sv
module crc_engine_chk #(
  parameter int SIZE_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [SIZE_W-1:0] cfg_size,
  input logic              cfg_ignore_bad,
  input logic              in_valid,
  input logic              in_sop,
  input logic              out_valid,
  input logic              out_last,
  input logic              rx_done,
  input logic              crc_ok
);
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && !out_last && !rx_done && !crc_ok)); // R1

  AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid); // R2

  AST_SIZE0_SILENT: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($past(cfg_size) != '0)); // R3

  AST_FAIL_SUPPRESSED: assert property (@(posedge clk) disable iff (rst)
    (rx_done && !crc_ok) |-> $past(cfg_ignore_bad)); // R10

  AST_OK_STICKY: assert property (@(posedge clk) disable iff (rst)
    !$stable(crc_ok) |-> (rx_done || $past(in_valid && in_sop))); // R11
endmodule

bind crc_engine crc_engine_chk #(.SIZE_W(SIZE_W)) chk_i (
  .clk           (clk),
  .rst           (rst),
  .cfg_size      (cfg_size),
  .cfg_ignore_bad(cfg_ignore_bad),
  .in_valid      (in_valid),
  .in_sop        (in_sop),
  .out_valid     (out_valid),
  .out_last      (out_last),
  .rx_done       (rx_done),
  .crc_ok        (crc_ok)
);

// File: tb/crc_engine_tb_top.sv
`timescale 1ns/1ps
module crc_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  cfg_size;
  logic [3:0]  cfg_skip;
  logic        cfg_refl_in, cfg_refl_out, cfg_msb_first, cfg_ignore_bad, tx_mode;
  logic [31:0] cfg_seed, cfg_poly, cfg_xor_out;
  logic        in_valid, in_sop, in_eod;
  logic [7:0]  in_data;
  logic        out_valid, out_last, rx_done, crc_ok;
  logic [7:0]  out_data;

  int checks = 0;
  int errors = 0;
  logic [7:0] pkt [0:15];

  always #2 clk = ~clk;

  crc_engine dut_i (
    .clk(clk), .rst(rst), .cfg_size(cfg_size), .cfg_skip(cfg_skip),
    .cfg_refl_in(cfg_refl_in), .cfg_refl_out(cfg_refl_out), .cfg_msb_first(cfg_msb_first),
    .cfg_seed(cfg_seed), .cfg_poly(cfg_poly), .cfg_xor_out(cfg_xor_out),
    .cfg_ignore_bad(cfg_ignore_bad), .tx_mode(tx_mode), .in_valid(in_valid),
    .in_sop(in_sop), .in_eod(in_eod), .in_data(in_data), .out_valid(out_valid),
    .out_data(out_data), .out_last(out_last), .rx_done(rx_done), .crc_ok(crc_ok)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int eff(input logic [2:0] s);
    return (s > 3'd4) ? 4 : int'(s);
  endfunction

  function automatic logic [31:0] model_crc(input int n);
    int w = 8 * eff(cfg_size);
    logic [31:0] mask, r, t;
    logic [7:0] d;
    if (w == 0) return 32'h0;
    mask = (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 32'h1);
    r = cfg_seed & mask;
    for (int i = int'(cfg_skip); i < n; i++) begin
      d = pkt[i];
      if (cfg_refl_in) for (int j = 0; j < 8; j++) d[j] = pkt[i][7-j];
      for (int b = 7; b >= 0; b--) begin
        logic fb;
        fb = r[w-1] ^ d[b];
        r  = (r << 1) & mask;
        if (fb) r = r ^ (cfg_poly & mask);
      end
    end
    if (cfg_refl_out) begin
      t = 32'h0;
      for (int j = 0; j < w; j++) t[j] = r[w-1-j];
      r = t;
    end
    return (r ^ cfg_xor_out) & mask;
  endfunction

  function automatic logic [7:0] crc_byte(input logic [31:0] c, input int k);
    int n = eff(cfg_size);
    int p = cfg_msb_first ? (n - 1 - k) : k;
    return c[8*p +: 8];
  endfunction

  task automatic send_data(input int n, input logic tx);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sop = (i == 0); in_eod = (i == n - 1);
      in_data = pkt[i]; tx_mode = tx;
    end
  endtask

  task automatic idle_in();
    in_valid = 1'b0; in_sop = 1'b0; in_eod = 1'b0; in_data = 8'h00;
  endtask

  task automatic tx_run(input string req, input int n, input logic [31:0] exp);
    int nb = eff(cfg_size);
    send_data(n, 1'b1);
    @(negedge clk);
    in_valid = 1'b1; in_data = 8'hA5;  // must be ignored during emission (R2)
    chk({req, " R2 no byte yet"}, 32'(out_valid), 32'd0);
    for (int k = 0; k < nb; k++) begin
      @(negedge clk);
      chk({req, " R2 valid"}, 32'(out_valid), 32'd1);
      chk({req, " R7 byte"}, 32'(out_data), 32'(crc_byte(exp, k)));
      chk({req, " R2 last"}, 32'(out_last), 32'(k == nb - 1));
    end
    idle_in();
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      chk({req, " R2/R3 quiet after"}, 32'(out_valid), 32'd0);
    end
  endtask

  task automatic rx_run(input string req, input int n, input logic corrupt,
                        input logic exp_done, input logic exp_ok);
    int nb = eff(cfg_size);
    logic [31:0] c = model_crc(n);
    send_data(n, 1'b0);
    for (int k = 0; k < nb; k++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sop = 1'b0; in_eod = 1'b0;
      in_data = crc_byte(c, k) ^ ((corrupt && k == 0) ? 8'h01 : 8'h00);
    end
    @(negedge clk);
    idle_in();
    chk({req, " R9/R10 rx_done"}, 32'(rx_done), 32'(exp_done));
    chk({req, " R9 crc_ok"}, 32'(crc_ok), 32'(exp_ok));
    @(negedge clk);
    chk({req, " R10 pulse"}, 32'(rx_done), 32'd0);
  endtask

  task automatic set_cfg(input logic [2:0] sz, input logic [3:0] sk, input logic ri,
                         input logic ro, input logic mf, input logic [31:0] sd,
                         input logic [31:0] pl, input logic [31:0] xo);
    cfg_size = sz; cfg_skip = sk; cfg_refl_in = ri; cfg_refl_out = ro;
    cfg_msb_first = mf; cfg_seed = sd; cfg_poly = pl; cfg_xor_out = xo;
  endtask

  task automatic load_digits();
    for (int i = 0; i < 9; i++) pkt[i] = 8'h31 + 8'(i);
  endtask

  task automatic t_reset();
    rst = 1'b1; idle_in(); tx_mode = 1'b0; cfg_ignore_bad = 1'b0;
    set_cfg(3'd4, 4'd0, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h0);
    repeat (3) @(negedge clk);
    chk("R1 out_valid in reset", 32'(out_valid), 32'd0);
    chk("R1 rx_done in reset", 32'(rx_done), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 crc_ok after reset", 32'(crc_ok), 32'd0);
    chk("R1 out_last after reset", 32'(out_last), 32'd0);
  endtask

  task automatic t_known_32();  // R5 R6 reflected 32-bit known answer
    load_digits();
    set_cfg(3'd4, 4'd0, 1'b1, 1'b1, 1'b0, 32'hFFFF_FFFF, 32'h04C1_1DB7, 32'hFFFF_FFFF);
    chk("R5/R6 model agrees with known value", model_crc(9), 32'hCBF4_3926);
    tx_run("R5/R6 known 32-bit", 9, 32'hCBF4_3926);
  endtask

  task automatic t_known_16();  // R7 most significant byte first, no reflection
    load_digits();
    set_cfg(3'd2, 4'd0, 1'b0, 1'b0, 1'b1, 32'h0000_FFFF, 32'h0000_1021, 32'h0);
    tx_run("R7 known 16-bit msb-first", 9, 32'h0000_29B1);
  endtask

  task automatic t_skip();
    for (int i = 0; i < 7; i++) pkt[i] = 8'h5A ^ 8'(i * 37);
    set_cfg(3'd3, 4'd3, 1'b0, 1'b1, 1'b0, 32'h0012_3456, 32'h0080_0063, 32'h00AB_CDEF);
    tx_run("R4 skip 3 bytes", 7, model_crc(7));
    set_cfg(3'd1, 4'd7, 1'b1, 1'b0, 1'b1, 32'h0000_00FF, 32'h0000_0007, 32'h0);
    tx_run("R4 skip covers whole packet", 7, 32'(8'hFF));
  endtask

  task automatic t_low_bits();
    for (int i = 0; i < 5; i++) pkt[i] = 8'hC3 + 8'(i);
    set_cfg(3'd2, 4'd0, 1'b0, 1'b0, 1'b0, 32'hABCD_1D0F, 32'h5555_8005, 32'h9999_0000);
    tx_run("R8 upper bits ignored", 5, model_crc(5));
    chk("R8 model equals clean-config value", model_crc(5),
        32'(crc16_clean(5)));
  endtask

  function automatic logic [15:0] crc16_clean(input int n);
    logic [15:0] r = 16'h1D0F;
    for (int i = 0; i < n; i++)
      for (int b = 7; b >= 0; b--) begin
        logic fb;
        fb = r[15] ^ pkt[i][b];
        r = {r[14:0], 1'b0};
        if (fb) r = r ^ 16'h8005;
      end
    return r;
  endfunction

  task automatic t_size_over();
    for (int i = 0; i < 4; i++) pkt[i] = 8'h10 * 8'(i + 1);
    set_cfg(3'd7, 4'd1, 1'b1, 1'b0, 1'b1, 32'h1357_9BDF, 32'h1EDC_6F41, 32'h0F0F_0F0F);
    tx_run("R12 size 7 acts as 4", 4, model_crc(4));
  endtask

  task automatic t_rx();
    for (int i = 0; i < 6; i++) pkt[i] = 8'h77 ^ 8'(i * 11);
    set_cfg(3'd3, 4'd1, 1'b1, 1'b1, 1'b1, 32'h00FF_FFFF, 32'h0086_4CFB, 32'h0);
    cfg_ignore_bad = 1'b0;
    rx_run("R9 good check", 6, 1'b0, 1'b1, 1'b1);
    repeat (3) @(negedge clk);
    chk("R11 crc_ok held while idle", 32'(crc_ok), 32'd1);
    rx_run("R10 bad check, ignore=0", 6, 1'b1, 1'b0, 1'b0);
    cfg_ignore_bad = 1'b1;
    rx_run("R10 bad check, ignore=1", 6, 1'b1, 1'b1, 1'b0);
    rx_run("R10 good check, ignore=1", 6, 1'b0, 1'b1, 1'b1);
    cfg_ignore_bad = 1'b0;
    // R11: new packet start clears the flag
    @(negedge clk);
    in_valid = 1'b1; in_sop = 1'b1; in_eod = 1'b0; in_data = pkt[0]; tx_mode = 1'b0;
    @(negedge clk);
    idle_in();
    chk("R11 cleared at new packet", 32'(crc_ok), 32'd0);
  endtask

  task automatic t_size0();
    for (int i = 0; i < 3; i++) pkt[i] = 8'h21 + 8'(i);
    set_cfg(3'd0, 4'd0, 1'b0, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'h04C1_1DB7, 32'h1);
    tx_run("R3 size 0 transmit", 3, 32'h0);
    rx_run("R3 size 0 receive", 3, 1'b0, 1'b1, 1'b1);
  endtask

  initial begin
    t_reset();
    t_known_32();
    t_known_16();
    t_skip();
    t_low_bits();
    t_size_over();
    t_rx();
    t_size0();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4ns * 100000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule